// File: doc/BRIEF.md
# Five-Level Page Table Walker

This block turns a 49-bit GPU virtual address into a 36-bit physical address by walking a five-level translation tree in memory. A walk starts from a directory base supplied on an input port. The block reads one 32-bit word at a time through a small memory read port. That port has a request strobe and returns data some cycles later with a valid pulse.

Levels 0 to 2 hold single-pointer directory entries of 8 bytes. Level 3 holds 16-byte dual entries. Each dual entry carries a pointer to a big-page (64 KB) leaf table and a pointer to a small-page (4 KB) leaf table, and the two pointers use different address shifts. Level 4 holds 8-byte leaf entries. The index width at level 4 depends on the page size chosen with the request.

A request is accepted on a valid/ready port with the address and a page-size select. Only one walk runs at a time. The result is returned on a valid/ready response port. It carries the physical address, the memory kind, the read-only and volatile attributes, the compression tag line, a fault code and the level at which the walk ended.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high only while no walk is active. After a request is accepted, `req_ready` stays low until the response handshake (`rsp_valid` and `rsp_ready` both high). While `rsp_valid` is high and `rsp_ready` is low, every response field holds its value.
- R2: At levels 0, 1 and 2 the entry word is read at table base + 8 × index. The index is VA[48:47] at level 0, VA[46:38] at level 1 and VA[37:29] at level 2. The next table base is word bits [31:8] shifted left by 12.
- R3: At level 3 the entry is 16 bytes at base + 16 × VA[28:21]. A small-page walk reads the word at byte offset 8 and takes its next base as bits [31:8] shifted left by 12. A big-page walk (`req_big`=1) reads the word at offset 0 and takes its next base as bits [31:4] shifted left by 8.
- R4: At level 4 the leaf sits at base + 8 × index. The index is VA[20:12] for small pages and VA[20:16] for big pages. The low word is read first, then the word at +4.
- R5: A directory word whose bits [2:1] are not 2 (2 means video memory) ends the walk at once. The response then has fault code 1, `rsp_level` equal to that level (0 to 3), and no further memory reads are issued. A fault at level L therefore costs L+1 reads.
- R6: For a valid leaf (low word bit 0 set), the physical page number is low-word bits [31:8]. The address is {page number, VA[11:0]} for small pages. For big pages, address bits [35:16] are page-number bits [23:4] and the low 16 bits are VA[15:0].
- R7: A valid leaf reports the following and returns fault code 0 and level 4:
  - `rsp_ro` from low-word bit 6
  - `rsp_vol` from high-word bit 3
  - `rsp_ctag` from high-word bits [21:4]
  - `rsp_kind` from high-word bits [31:24]
- R8: A leaf with bit 0 clear returns level 4 with address, kind, read-only and tag all zero. If high-word bit 3 is set, the leaf is sparse: fault code 3 with `rsp_vol`=1. Otherwise it is unmapped: fault code 2 with `rsp_vol`=0.
- R9: At most one memory read is outstanding. `mem_req` is a single-cycle pulse, the next pulse comes only after `mem_rvalid`, and no pulse occurs while a response is pending. A complete walk issues exactly 6 reads.
- R10: After reset `req_ready` is 1 and `rsp_valid` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_base | input | 36 | Byte address of the level-0 table, sampled at acceptance |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_va | input | 49 | Virtual address to translate |
| req_big | input | 1 | 1 selects 64 KB pages, 0 selects 4 KB pages |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_pa | output | 36 | Physical address |
| rsp_kind | output | 8 | Memory kind of the page |
| rsp_ro | output | 1 | Page is read-only |
| rsp_vol | output | 1 | Page is volatile (uncached) |
| rsp_ctag | output | 18 | Compression tag line field of the leaf |
| rsp_fault | output | 2 | 0 ok, 1 directory fault, 2 unmapped, 3 sparse |
| rsp_level | output | 3 | Level at which the walk ended |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 36 | Byte address of the word to read |
| mem_rdata | input | 32 | Read data, valid with mem_rvalid |
| mem_rvalid | input | 1 | Read data valid |

## Verification
A wrong level counter or a wrong table base sends a read to an address where the bench memory holds nothing. The word that comes back is zero, so the walk ends in a directory or unmapped fault within the same request, and the read count differs from the expected value. Picking the wrong slot of a dual entry or the wrong shift for the big pointer also faults, because the bench writes an invalid word into the slot that should not be used. A broken leaf field slice shows up as a wrong address, kind, tag or attribute on the very next response. A broken handshake shows up as `req_ready` rising during a walk or response fields changing while the response is held.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
    localparam int VA_W      = 49;
    localparam int PA_W      = 36;
    localparam int WORD_W    = 32;
    localparam int PPN_W     = 24;
    localparam int KIND_W    = 8;
    localparam int CTAG_W    = 18;
    localparam int LVL_W     = 3;
    localparam int OFF_W     = 13;
    localparam int BIGPTR_W  = WORD_W - 4;

    localparam logic [LVL_W-1:0] LVL_DUAL = 3'd3;
    localparam logic [LVL_W-1:0] LVL_LEAF = 3'd4;
    localparam logic [1:0]       APER_VID = 2'd2;

    localparam logic [1:0] FLT_NONE     = 2'd0;
    localparam logic [1:0] FLT_DIR      = 2'd1;
    localparam logic [1:0] FLT_UNMAPPED = 2'd2;
    localparam logic [1:0] FLT_SPARSE   = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } walk_state_e;

    typedef struct packed {
        walk_state_e       state;
        logic [LVL_W-1:0]  lvl;
        logic              wsel;
        logic [VA_W-1:0]   va;
        logic              big;
        logic [PA_W-1:0]   base;
        logic              leaf_valid;
        logic              leaf_ro;
        logic [PPN_W-1:0]  leaf_ppn;
        logic [PA_W-1:0]   pa;
        logic [KIND_W-1:0] kind;
        logic              ro;
        logic              vol;
        logic [CTAG_W-1:0] ctag;
        logic [1:0]        fault;
    } walk_regs_t;
endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr
    import pt_walker_pkg::*;
(
    input  logic [PA_W-1:0]  base,
    input  logic [VA_W-1:0]  va,
    input  logic [LVL_W-1:0] lvl,
    input  logic             big,
    input  logic             wsel,
    output logic [PA_W-1:0]  addr
);
    logic [OFF_W-1:0] off;

    always_comb begin
        case (lvl)
            3'd0:    off = OFF_W'({va[48:47], 3'b000});
            3'd1:    off = OFF_W'({va[46:38], 3'b000});
            3'd2:    off = OFF_W'({va[37:29], 3'b000});
            3'd3:    off = OFF_W'({va[28:21], 4'b0000}) + (big ? OFF_W'(0) : OFF_W'(8));
            default: off = (big ? OFF_W'({va[20:16], 3'b000}) : OFF_W'({va[20:12], 3'b000}))
                           + (wsel ? OFF_W'(4) : OFF_W'(0));
        endcase
        addr = base + PA_W'(off);
    end
endmodule

// File: rtl/pt_dir_decode.sv
module pt_dir_decode
    import pt_walker_pkg::*;
(
    input  logic [1:0]          aper,
    input  logic [BIGPTR_W-1:0] ptr,
    input  logic                dual_big,
    output logic                ok,
    output logic [PA_W-1:0]     next_base
);
    always_comb begin
        ok = (aper == APER_VID);
        if (dual_big)
            next_base = {ptr, 8'h00};
        else
            next_base = {ptr[BIGPTR_W-1:4], 12'h000};
    end
endmodule

// File: rtl/pt_leaf_decode.sv
module pt_leaf_decode
    import pt_walker_pkg::*;
(
    input  logic              valid,
    input  logic              ro_bit,
    input  logic [PPN_W-1:0]  ppn,
    input  logic              vol_bit,
    input  logic [CTAG_W-1:0] ctag_f,
    input  logic [KIND_W-1:0] kind_f,
    input  logic [15:0]       va_lo,
    input  logic              big,
    output logic [PA_W-1:0]   pa,
    output logic [KIND_W-1:0] kind,
    output logic              ro,
    output logic              vol,
    output logic [CTAG_W-1:0] ctag,
    output logic [1:0]        fault
);
    always_comb begin
        pa    = '0;
        kind  = '0;
        ro    = 1'b0;
        ctag  = '0;
        vol   = vol_bit;
        fault = vol_bit ? FLT_SPARSE : FLT_UNMAPPED;
        if (valid) begin
            pa    = big ? {ppn[PPN_W-1:4], va_lo} : {ppn, va_lo[11:0]};
            kind  = kind_f;
            ro    = ro_bit;
            ctag  = ctag_f;
            fault = FLT_NONE;
        end
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PA_W-1:0]   dir_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_big,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [KIND_W-1:0] rsp_kind,
    output logic              rsp_ro,
    output logic              rsp_vol,
    output logic [CTAG_W-1:0] rsp_ctag,
    output logic [1:0]        rsp_fault,
    output logic [LVL_W-1:0]  rsp_level,
    output logic              mem_req,
    output logic [PA_W-1:0]   mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_rvalid
);
    walk_regs_t q, d;

    logic              dir_ok;
    logic [PA_W-1:0]   dir_next;
    logic [PA_W-1:0]   lf_pa;
    logic [KIND_W-1:0] lf_kind;
    logic              lf_ro;
    logic              lf_vol;
    logic [CTAG_W-1:0] lf_ctag;
    logic [1:0]        lf_fault;

    pt_entry_addr u_addr (
        .base (q.base),
        .va   (q.va),
        .lvl  (q.lvl),
        .big  (q.big),
        .wsel (q.wsel),
        .addr (mem_addr)
    );

    pt_dir_decode u_dir (
        .aper      (mem_rdata[2:1]),
        .ptr       (mem_rdata[WORD_W-1:4]),
        .dual_big  ((q.lvl == LVL_DUAL) && q.big),
        .ok        (dir_ok),
        .next_base (dir_next)
    );

    pt_leaf_decode u_leaf (
        .valid   (q.leaf_valid),
        .ro_bit  (q.leaf_ro),
        .ppn     (q.leaf_ppn),
        .vol_bit (mem_rdata[3]),
        .ctag_f  (mem_rdata[21:4]),
        .kind_f  (mem_rdata[31:24]),
        .va_lo   (q.va[15:0]),
        .big     (q.big),
        .pa      (lf_pa),
        .kind    (lf_kind),
        .ro      (lf_ro),
        .vol     (lf_vol),
        .ctag    (lf_ctag),
        .fault   (lf_fault)
    );

    always_comb begin
        d         = q;
        req_ready = (q.state == ST_IDLE);
        mem_req   = (q.state == ST_ISSUE);
        rsp_valid = (q.state == ST_RESP);
        case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.state = ST_ISSUE;
                    d.va    = req_va;
                    d.big   = req_big;
                    d.base  = dir_base;
                    d.lvl   = '0;
                    d.wsel  = 1'b0;
                    d.pa    = '0;
                    d.kind  = '0;
                    d.ro    = 1'b0;
                    d.vol   = 1'b0;
                    d.ctag  = '0;
                    d.fault = FLT_NONE;
                end
            end
            ST_ISSUE: d.state = ST_WAIT;
            ST_WAIT: begin
                if (mem_rvalid) begin
                    if (q.lvl < LVL_LEAF) begin
                        if (dir_ok) begin
                            d.base  = dir_next;
                            d.lvl   = q.lvl + 3'd1;
                            d.state = ST_ISSUE;
                        end else begin
                            d.fault = FLT_DIR;
                            d.state = ST_RESP;
                        end
                    end else if (!q.wsel) begin
                        d.leaf_valid = mem_rdata[0];
                        d.leaf_ro    = mem_rdata[6];
                        d.leaf_ppn   = mem_rdata[31:8];
                        d.wsel       = 1'b1;
                        d.state      = ST_ISSUE;
                    end else begin
                        d.pa    = lf_pa;
                        d.kind  = lf_kind;
                        d.ro    = lf_ro;
                        d.vol   = lf_vol;
                        d.ctag  = lf_ctag;
                        d.fault = lf_fault;
                        d.state = ST_RESP;
                    end
                end
            end
            ST_RESP: if (rsp_ready) d.state = ST_IDLE;
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rsp_pa    = q.pa;
    assign rsp_kind  = q.kind;
    assign rsp_ro    = q.ro;
    assign rsp_vol   = q.vol;
    assign rsp_ctag  = q.ctag;
    assign rsp_fault = q.fault;
    assign rsp_level = q.lvl;

    AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R1
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_fault) && $stable(rsp_kind))); // R1
    AST_DIR_FAULT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FLT_DIR) |-> (rsp_level < LVL_LEAF)); // R5
    AST_LEAF_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != FLT_DIR) |-> (rsp_level == LVL_LEAF)); // R7
    AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_pa == '0 && rsp_kind == '0)); // R8
    AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R9
    AST_NO_READ_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !mem_req); // R9
endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
    import pt_walker_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PA_W-1:0]   dir_base = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [VA_W-1:0]   req_va = '0;
    logic              req_big = 1'b0;
    logic              rsp_valid;
    logic              rsp_ready = 1'b0;
    logic [PA_W-1:0]   rsp_pa;
    logic [KIND_W-1:0] rsp_kind;
    logic              rsp_ro;
    logic              rsp_vol;
    logic [CTAG_W-1:0] rsp_ctag;
    logic [1:0]        rsp_fault;
    logic [LVL_W-1:0]  rsp_level;
    logic              mem_req;
    logic [PA_W-1:0]   mem_addr;
    logic [WORD_W-1:0] mem_rdata = '0;
    logic              mem_rvalid = 1'b0;

    int checks = 0;
    int errors = 0;
    int nreads = 0;

    logic [31:0]     mem [logic [35:0]];
    logic            pend = 1'b0;
    logic [PA_W-1:0] paddr = '0;
    int              lat = 0;

    always #2.5 clk = ~clk;

    pt_walker dut (.*);

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (pend) begin
            if (lat == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem.exists(paddr) ? mem[paddr] : 32'h0;
                pend       <= 1'b0;
            end else lat <= lat - 1;
        end
        if (mem_req) begin
            pend   <= 1'b1;
            paddr  <= mem_addr;
            lat    <= int'($urandom % 3);
            nreads <= nreads + 1;
        end
    end

    task automatic chk(input string r, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", r, what, act, exp);
        end
    endtask

    function automatic [31:0] enc_pde(input [35:0] a, input [1:0] ap);
        return {a[35:12], 5'b00000, ap, 1'b0};
    endfunction
    function automatic [31:0] enc_big(input [35:0] a, input [1:0] ap);
        return {a[35:8], 1'b0, ap, 1'b0};
    endfunction
    function automatic [31:0] enc_pte0(input [23:0] ppn, input v, input ro);
        return {ppn, 1'b0, ro, 5'b00000, v};
    endfunction
    function automatic [31:0] enc_pte1(input [7:0] kind, input [17:0] ctag, input vol);
        return {kind, 2'b00, ctag, vol, 3'b000};
    endfunction
    function automatic [35:0] ent_addr(input [35:0] b, input int l, input [48:0] va, input big, input hi);
        case (l)
            0: return b + 36'({va[48:47], 3'b000});
            1: return b + 36'({va[46:38], 3'b000});
            2: return b + 36'({va[37:29], 3'b000});
            3: return b + 36'({va[28:21], 4'b0000}) + (hi ? 36'd8 : 36'd0);
            default: return big ? b + 36'({va[20:16], 3'b000}) : b + 36'({va[20:12], 3'b000});
        endcase
    endfunction
    function automatic [35:0] exp_pa(input [23:0] ppn, input [48:0] va, input big);
        return big ? {ppn[23:4], va[15:0]} : {ppn, va[11:0]};
    endfunction

    // stop_lvl < 0: no directory fault; leaf_mode 0 valid, 1 unmapped, 2 sparse
    task automatic walk(input [48:0] va, input big, input int stop_lvl, input [1:0] bad_ap,
                        input int leaf_mode, input ro, input vol, input [7:0] kind,
                        input [17:0] ctag, input [23:0] ppn);
        logic [35:0] b, nx, ea;
        int start, hold;
        logic [35:0] e_pa; logic [7:0] e_kind; logic e_ro, e_vol; logic [17:0] e_ctag;
        logic [1:0] e_flt; int e_lvl, e_reads;
        logic [35:0] h_pa; logic [1:0] h_flt;
        mem.delete();
        b = {4'h0, 32'($urandom) & 32'h0FFF_F000};
        dir_base = b;
        e_lvl = 4;
        for (int l = 0; l < 4; l++) begin
            logic [1:0] ap;
            ap = (l == stop_lvl) ? bad_ap : 2'd2;
            if (l == 3 && big) nx = (36'(l + 1) << 32) | 36'(32'($urandom) & 32'h0FFF_FF00);
            else               nx = (36'(l + 1) << 32) | 36'(32'($urandom) & 32'h0FFF_F000);
            if (l == 3) begin
                ea = ent_addr(b, 3, va, big, !big);
                mem[ent_addr(b, 3, va, big, big)] = 32'h0;
                mem[ea] = big ? enc_big(nx, ap) : enc_pde(nx, ap);
            end else begin
                ea = ent_addr(b, l, va, big, 1'b0);
                mem[ea] = enc_pde(nx, ap);
            end
            if (l == stop_lvl) begin e_lvl = l; break; end
            b = nx;
        end
        e_pa = '0; e_kind = '0; e_ro = 0; e_vol = 0; e_ctag = '0;
        if (stop_lvl >= 0) begin
            e_flt = FLT_DIR; e_reads = stop_lvl + 1;
        end else begin
            ea = ent_addr(b, 4, va, big, 1'b0);
            e_reads = 6;
            if (leaf_mode == 0) begin
                mem[ea] = enc_pte0(ppn, 1'b1, ro);
                mem[ea + 36'd4] = enc_pte1(kind, ctag, vol);
                e_flt = FLT_NONE; e_pa = exp_pa(ppn, va, big);
                e_kind = kind; e_ro = ro; e_vol = vol; e_ctag = ctag;
            end else if (leaf_mode == 1) begin
                mem[ea] = 32'h0; mem[ea + 36'd4] = 32'h0; e_flt = FLT_UNMAPPED;
            end else begin
                mem[ea] = enc_pte0(ppn, 1'b0, ro);
                mem[ea + 36'd4] = enc_pte1(kind, ctag, 1'b1);
                e_flt = FLT_SPARSE; e_vol = 1;
            end
        end
        @(negedge clk);
        start = nreads;
        chk("R1", "ready idle", req_ready, 1);
        req_valid = 1'b1; req_va = va; req_big = big;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) begin
            chk("R1", "ready busy", req_ready, 0);
            @(negedge clk);
        end
        chk("R5", "fault", rsp_fault, e_flt);
        chk("R5", "level", rsp_level, e_lvl);
        chk("R6", "pa", rsp_pa, e_pa);
        chk("R7", "kind", rsp_kind, e_kind);
        chk("R7", "ro", rsp_ro, e_ro);
        chk("R8", "vol", rsp_vol, e_vol);
        chk("R7", "ctag", rsp_ctag, e_ctag);
        chk("R9", "reads", nreads - start, e_reads);
        h_pa = rsp_pa; h_flt = rsp_fault;
        hold = int'($urandom % 3);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk("R1", "hold valid", rsp_valid, 1);
            chk("R1", "hold pa", rsp_pa, h_pa);
            chk("R1", "hold fault", rsp_fault, h_flt);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R1", "rsp drop", rsp_valid, 0);
        chk("R1", "ready back", req_ready, 1);
    endtask

    function automatic [48:0] rva();
        return {17'($urandom), 32'($urandom)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #1;
        chk("R10", "reset ready", req_ready, 1);
        chk("R10", "reset rsp_valid", rsp_valid, 0);
        chk("R10", "reset mem_req", mem_req, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 R3 R4 R6 R7: valid small and big walks
        walk(rva(), 1'b0, -1, 2'd0, 0, 1'b1, 1'b0, 8'hA5, 18'h2_1234, 24'hABCDEF);
        walk(rva(), 1'b1, -1, 2'd0, 0, 1'b0, 1'b1, 8'h3C, 18'h3_FFFF, 24'h12345F);
        // boundary indices: all ones and all zeros
        walk({49{1'b1}}, 1'b0, -1, 2'd0, 0, 1'b1, 1'b1, 8'hFF, 18'h0_0001, 24'hFFFFFF);
        walk({49{1'b1}}, 1'b1, -1, 2'd0, 0, 1'b0, 1'b0, 8'h01, 18'h0_0000, 24'h00001F);
        walk(49'h0, 1'b0, -1, 2'd0, 0, 1'b0, 1'b0, 8'h00, 18'h1_0000, 24'h000001);
        // R5: directory faults at each level with each bad aperture
        for (int l = 0; l < 4; l++) begin
            walk(rva(), 1'b0, l, 2'd0, 0, 0, 0, 0, 0, 0);
            walk(rva(), 1'b1, l, 2'd1, 0, 0, 0, 0, 0, 0);
            walk(rva(), l[0], l, 2'd3, 0, 0, 0, 0, 0, 0);
        end
        // R8: unmapped and sparse leaves
        walk(rva(), 1'b0, -1, 2'd0, 1, 0, 0, 8'h55, 18'h1, 24'h777777);
        walk(rva(), 1'b1, -1, 2'd0, 1, 0, 0, 8'h55, 18'h1, 24'h777777);
        walk(rva(), 1'b0, -1, 2'd0, 2, 1, 1, 8'h77, 18'h5, 24'h999999);
        walk(rva(), 1'b1, -1, 2'd0, 2, 1, 1, 8'h77, 18'h5, 24'h999999);
        // random mix
        for (int n = 0; n < 40; n++) begin
            int sl, lm;
            sl = ($urandom % 4 == 0) ? int'($urandom % 4) : -1;
            lm = ($urandom % 4 == 0) ? int'(1 + $urandom % 2) : 0;
            walk(rva(), 1'($urandom), sl, ($urandom % 2) ? 2'd0 : 2'd3, lm,
                 1'($urandom), 1'($urandom), 8'($urandom), 18'($urandom), 24'($urandom));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule